// File: doc/BRIEF.md
# DMA Page Translation Walker

This block turns a 32-bit logical address issued by a DMA-capable device into a physical address. The translation uses one flat table kept in system memory. Each 8-byte table slot describes one 4096-byte page. Software writes two registers: the byte address where the table starts, and the table size in bytes.

A client hands over a logical address with a valid/ready handshake. The walker takes the page number from the address and checks it against the number of slots the table holds.

- If the page is inside the table, the walker reads the first word of the matching slot through a simple memory read port. It waits as long as the memory needs.
- If the page is outside the table, or the memory read reports an error, the result carries a zero page frame and a raised fault flag.

In every case the 12-bit offset inside the page passes through unchanged. The walker handles one walk at a time.

Top module: `dma_xlate_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0. The base and limit registers are cleared to zero.
- R2: A request is accepted only while `req_ready` is 1. From that accepting edge until the response is consumed, `req_ready` stays 0. Any request offered during that time is ignored and causes no memory read.
- R3: The page number is the logical address shifted right by 12. A page is inside the table exactly when its number is less than the limit register shifted right by 3.
- R4: For a page outside the table, no memory read is issued. `rsp_valid` rises in the cycle after acceptance, with `rsp_fault` = 1 and `rsp_paddr` = {20'b0, logical[11:0]}.
- R5: For a page inside the table, `mem_req` rises in the cycle after acceptance. `mem_addr` equals the base register with bit 31 forced to 0, plus the page number times 8. Both stay steady for any number of cycles until `mem_ack`.
- R6: When `mem_ack` arrives with `mem_err` = 0, `rsp_valid` rises on the next cycle with `rsp_fault` = 0 and `rsp_paddr` = {mem_rdata[31:12], logical[11:0]}. The low 12 bits of the fetched word are discarded.
- R7: When `mem_ack` arrives with `mem_err` = 1, the response carries `rsp_fault` = 1 and `rsp_paddr` = {20'b0, logical[11:0]}.
- R8: `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady until `rsp_ready` is seen. On the edge where it is seen, the walker returns to idle with `req_ready` = 1.
- R9: A write with `cfg_we` = 1 updates the base register when `cfg_sel` = 0 and the limit register when `cfg_sel` = 1. A write made during a walk does not change that walk's range decision or fetch address. The next walk uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table limit |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_addr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 32 | Physical address (frame and offset) |
| rsp_fault | output | 1 | Out of range or failed fetch |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Byte address of the table slot |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | First word of the table slot |
| mem_err | input | 1 | Read failed (with `mem_ack`) |

## Verification
A wrong page number or a base mask applied badly shows up first on `mem_addr`. It is visible in the cycle right after acceptance, before any response exists. A wrong range decision shows up one cycle after acceptance: `mem_req` and `rsp_valid` trade places, so the fault path and the fetch path can be told apart at once. A corrupted state register either leaves `req_ready` low after a consumed response, or lets a probe offered mid-walk start a second read. Either is seen within one cycle of the handshake in question.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } xlt_state_e;

  localparam int unsigned CFG_SEL_BASE  = 0;
  localparam int unsigned CFG_SEL_LIMIT = 1;
endpackage

// File: rtl/xlt_cfg_regs.sv
module xlt_cfg_regs #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] limit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (we) begin
      if (sel == 1'(xlt_pkg::CFG_SEL_LIMIT)) limit_q <= wdata;
      else                                   base_q  <= wdata;
    end
  end
endmodule

// File: rtl/xlt_range_check.sv
module xlt_range_check #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned ENTRY_SHIFT = 3
) (
  input  logic [ADDR_W-1:0] laddr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              in_range,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam logic [ADDR_W-1:0] BASE_MASK = {1'b0, {(ADDR_W-1){1'b1}}};

  logic [ADDR_W-1:0] page_idx;
  logic [ADDR_W-1:0] slot_cnt;

  always_comb begin
    page_idx   = laddr >> PAGE_BITS;
    slot_cnt   = limit >> ENTRY_SHIFT;
    in_range   = (page_idx < slot_cnt);
    entry_addr = (base & BASE_MASK) + (page_idx << ENTRY_SHIFT);
  end
endmodule

// File: rtl/xlt_walk_fsm.sv
module xlt_walk_fsm #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [PAGE_BITS-1:0]        req_off,
  input  logic                        in_range,
  input  logic [ADDR_W-1:0]           entry_addr,
  output logic                        req_ready,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [ADDR_W-1:0]           rsp_paddr,
  output logic                        rsp_fault,
  output logic                        mem_req,
  output logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_ack,
  input  logic [ADDR_W-PAGE_BITS-1:0] mem_frame,
  input  logic                        mem_err
);
  import xlt_pkg::*;

  localparam int unsigned FRAME_W = ADDR_W - PAGE_BITS;

  xlt_state_e           state_q;
  logic [PAGE_BITS-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      off_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            off_q     <= req_off;
            req_ready <= 1'b0;
            if (in_range) begin
              mem_req  <= 1'b1;
              mem_addr <= entry_addr;
              state_q  <= ST_FETCH;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= {{FRAME_W{1'b0}}, req_off};
              state_q   <= ST_RESP;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_fault <= mem_err;
            rsp_paddr <= mem_err ? {{FRAME_W{1'b0}}, off_q}
                                 : {mem_frame, off_q};
            state_q   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            req_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_err
);
  localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic [ADDR_W-1:0] base_q, limit_q, entry_addr;
  logic              in_range;

  xlt_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_q(base_q), .limit_q(limit_q)
  );

  xlt_range_check #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_range (
    .laddr(req_addr), .base(base_q), .limit(limit_q),
    .in_range(in_range), .entry_addr(entry_addr)
  );

  xlt_walk_fsm #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_off(req_addr[PAGE_BITS-1:0]),
    .in_range(in_range), .entry_addr(entry_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_frame(mem_rdata[ADDR_W-1:PAGE_BITS]), .mem_err(mem_err)
  );
endmodule

// File: rtl/xlt_walker_chk.sv
module xlt_walker_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_ready && !rsp_valid && !mem_req));

  a_r2_busy_exclusive: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!rsp_valid && !mem_req));

  a_r5_fetch_steady: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r6_ack_to_rsp: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (rsp_valid && !mem_req));

  a_r7_fault_zero_frame: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr[ADDR_W-1:PAGE_BITS] == '0));

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  a_r8_back_to_idle: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));
endmodule

bind dma_xlate_walker xlt_walker_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/dma_xlate_walker_test.sv
`timescale 1ns/1ps
module dma_xlate_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_ready = 1'b0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_req;
  logic [31:0] rsp_paddr, mem_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] tb_base, tb_limit;

  localparam logic [31:0] NEW_BASE = 32'h0020_0000;

  // {addr[31:0], latency[7:0], err, mode[1:0]}; mode 1 = probe request, 2 = base write mid-walk
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {32'h0000_0ABC, 8'd0, 1'b0, 2'd0},
    {32'h0000_F123, 8'd3, 1'b0, 2'd0},
    {32'h0001_0000, 8'd0, 1'b0, 2'd0},
    {32'h0000_5FFF, 8'd1, 1'b1, 2'd0},
    {32'hFFFF_F001, 8'd0, 1'b0, 2'd0},
    {32'h0000_7000, 8'd4, 1'b0, 2'd1},
    {32'h0000_2468, 8'd3, 1'b0, 2'd2},
    {32'h0000_3001, 8'd2, 1'b0, 2'd0}
  };

  dma_xlate_walker uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] ea);
    return {ea[27:8] ^ 20'h5A3C1, 12'hFED};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    if (sel) tb_limit = d; else tb_base = d;
  endtask

  task automatic finish_rsp(input logic [31:0] ep, input logic ef, input string req);
    chk({31'b0, rsp_valid}, 32'd1, req);
    chk(rsp_paddr, ep, req);
    chk({31'b0, rsp_fault}, {31'b0, ef}, req);
    @(negedge clk);
    chk({rsp_valid, rsp_fault, 30'b0}, {1'b1, ef, 30'b0}, "R8 hold");
    chk(rsp_paddr, ep, "R8 hold");
    rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
    chk({req_ready, rsp_valid, mem_req}, 3'b100, "R8 idle");
  endtask

  task automatic walk(input logic [31:0] a, input int lat, input logic err, input logic [1:0] mode);
    logic [31:0] idx, ent, ep;
    logic inr, ef;
    idx = a >> 12;
    inr = idx < (tb_limit >> 3);
    ent = (tb_base & 32'h7FFF_FFFF) + (idx << 3);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    chk({31'b0, req_ready}, 32'd1, "R2 ready");
    @(negedge clk); req_valid = 1'b0;
    if (!inr) begin
      chk({31'b0, mem_req}, 32'd0, "R4 no fetch");
      finish_rsp({20'b0, a[11:0]}, 1'b1, "R4 R3 out of range");
      return;
    end
    chk({31'b0, mem_req}, 32'd1, "R5 req");
    chk(mem_addr, ent, "R5 R3 entry addr");
    for (int i = 0; i < lat; i++) begin
      if (mode == 2'd1) begin req_valid = 1'b1; req_addr = 32'h0000_1000; end
      if (mode == 2'd2) begin
        cfg_we = (i == 0); cfg_sel = 1'b0; cfg_wdata = NEW_BASE;
      end
      @(negedge clk);
      chk({req_ready, mem_req}, 2'b01, "R2 busy");
      chk(mem_addr, ent, "R5 R9 addr steady");
    end
    cfg_we = 1'b0;
    if (mode == 2'd2) tb_base = NEW_BASE;
    mem_ack = 1'b1; mem_err = err; mem_rdata = mem_word(ent);
    @(negedge clk); mem_ack = 1'b0; mem_err = 1'b0; req_valid = 1'b0;
    ef = err;
    ep = err ? {20'b0, a[11:0]} : {mem_word(ent)[31:12], a[11:0]};
    finish_rsp(ep, ef, err ? "R7 bus error" : "R6 translate");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({req_ready, rsp_valid, mem_req}, 3'b100, "R1 reset");
    rst = 1'b0;
    tb_base = '0; tb_limit = '0;
    // R9: base with top bit set, limit of 16 slots
    cfg_write(1'b0, 32'h8010_0000);
    cfg_write(1'b1, 32'h0000_0080);
    for (int v = 0; v < NV; v++)
      walk(VEC[v][42:11], int'(VEC[v][10:3]), VEC[v][2], VEC[v][1:0]);
    // R3 limit boundaries
    cfg_write(1'b1, 32'd0);  walk(32'h0000_0010, 0, 1'b0, 2'd0);
    cfg_write(1'b1, 32'd7);  walk(32'h0000_0020, 0, 1'b0, 2'd0);
    cfg_write(1'b1, 32'd8);  walk(32'h0000_0030, 1, 1'b0, 2'd0);
    walk(32'h0000_1030, 0, 1'b0, 2'd0);
    // R1: reset in the middle of a fetch
    @(negedge clk); req_valid = 1'b1; req_addr = 32'h0000_0044;
    @(negedge clk); req_valid = 1'b0;
    chk({31'b0, mem_req}, 32'd1, "R1 pre-reset fetch");
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk({req_ready, rsp_valid, mem_req}, 3'b100, "R1 mid-walk reset");
    tb_base = '0; tb_limit = '0;
    walk(32'h0000_0044, 0, 1'b0, 2'd0); // R1 limit cleared -> out of range
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule